// File: doc/BRIEF.md
# Two-Output Prioritised Interrupt Vector Controller

The block gathers a bank of level-sensitive interrupt request lines and folds them onto two processor interrupt outputs: a fast output, which the processor treats as the more urgent one, and a normal output. Each channel has an enable bit and a routing bit. The routing bit sends the channel to the fast output when set and to the normal output when clear. A channel counts as pending only while its request line is high.

For each output, the block keeps a vector register. It holds the number of the highest-ranked pending, enabled channel routed to that output. The highest channel number has the highest rank. Firmware reads this register in its handler entry code and uses the number as an offset into its own table of handler addresses. The two interrupt outputs and both vector registers are registered, so they follow the request, enable and routing state with one clock of latency.

Firmware reaches the enable, routing and vector registers through a small word-wide register port. Writes are single-cycle. The read path is combinational.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset every channel is disabled (enable register, address 1, reads 0) and routed to the normal output (routing register, address 0, reads 0).
- R2: One cycle after the inputs are sampled, `fiq_o` is high exactly when some channel has its request high, its enable bit 1 and its routing bit 1.
- R3: One cycle after the inputs are sampled, `irq_o` is high exactly when some channel has its request high, its enable bit 1 and its routing bit 0.
- R4: The fast vector register (address 2) holds the highest-numbered channel that was pending for the fast output one cycle earlier. The number sits in bits [4:0] and bit 31 is a valid flag equal to `fiq_o`.
- R5: The normal vector register (address 3) has the same layout and gives the highest-numbered channel pending for the normal output.
- R6: When no channel is pending for an output, its vector register reads all zeros: index 0 with the valid flag clear.
- R7: Requests are levels. A channel whose line falls stops contributing to the outputs and vector registers one cycle later.
- R8: A disabled channel has no effect on either output or either vector register, whatever its request level.
- R9: Writes to the vector registers, and to any address from 4 to 7, are ignored. Addresses 4 to 7 read as 0.
- R10: A write to the enable or routing register takes effect on the clock edge where it is sampled. It reads back at once and governs the outputs from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Level interrupt requests, one per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data at `reg_addr_i` |
| fiq_o | output | 1 | Fast processor interrupt |
| irq_o | output | 1 | Normal processor interrupt |

## Verification
The bench builds the block with its default of 32 channels. At that width the valid flag falls on the same bit as the top channel of the enable and routing words, and channel 31 is the top of the ranking, so both edges of the index encoding are reachable. Random request patterns are mixed with rewrites of the enable and routing words in the same cycles as request changes, which exercises the one-cycle hand-off between a register update and the outputs. Stray writes to the read-only and unmapped addresses test that the model state stays untouched.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_ROUTE   = 3'd0,
    A_ENABLE  = 3'd1,
    A_FIQ_VEC = 3'd2,
    A_IRQ_VEC = 3'd3
  } ivc_addr_e;

  localparam int unsigned N_OUT = 2;
  localparam int unsigned O_FIQ = 0;
  localparam int unsigned O_IRQ = 1;
endpackage

// File: rtl/ivc_cfg_regs.sv
module ivc_cfg_regs
  import ivc_pkg::*;
#(
  parameter int unsigned N_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_CH-1:0]   wdata_i,
  output logic [N_CH-1:0]   en_o,
  output logic [N_CH-1:0]   route_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      route_o <= '0;
    end else if (we_i) begin
      if (addr_i == A_ENABLE) en_o    <= wdata_i;
      if (addr_i == A_ROUTE)  route_o <= wdata_i;
    end
  end
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  // ascending scan: the last hit, i.e. the highest channel, wins
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (pend_i[i]) begin
        idx_o = IDX_W'(i);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned N_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N_CH-1:0]   reg_wdata_i,
  output logic [N_CH-1:0]   reg_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = $clog2(N_CH);

  logic [N_CH-1:0]  en_q, route_q;
  logic [N_CH-1:0]  pend   [N_OUT];
  logic [IDX_W-1:0] enc_idx[N_OUT];
  logic             enc_vld[N_OUT];
  logic [IDX_W-1:0] fiq_idx_q, irq_idx_q;

  ivc_cfg_regs #(.N_CH(N_CH)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .en_o    (en_q),
    .route_o (route_q)
  );

  assign pend[O_FIQ] = req_i & en_q & route_q;
  assign pend[O_IRQ] = req_i & en_q & ~route_q;

  for (genvar g = 0; g < N_OUT; g++) begin : g_enc
    ivc_prio_enc #(.N_CH(N_CH), .IDX_W(IDX_W)) u_enc (
      .pend_i (pend[g]),
      .idx_o  (enc_idx[g]),
      .vld_o  (enc_vld[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fiq_o     <= 1'b0;
      irq_o     <= 1'b0;
      fiq_idx_q <= '0;
      irq_idx_q <= '0;
    end else begin
      fiq_o     <= enc_vld[O_FIQ];
      irq_o     <= enc_vld[O_IRQ];
      fiq_idx_q <= enc_idx[O_FIQ];
      irq_idx_q <= enc_idx[O_IRQ];
    end
  end

  function automatic logic [N_CH-1:0] vec_word(input logic vld, input logic [IDX_W-1:0] idx);
    logic [N_CH-1:0] w;
    w = '0;
    w[IDX_W-1:0] = idx;
    w[N_CH-1]    = vld;
    return w;
  endfunction

  always_comb begin
    case (reg_addr_i)
      A_ROUTE:   reg_rdata_o = route_q;
      A_ENABLE:  reg_rdata_o = en_q;
      A_FIQ_VEC: reg_rdata_o = vec_word(fiq_o, fiq_idx_q);
      A_IRQ_VEC: reg_rdata_o = vec_word(irq_o, irq_idx_q);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned IDX_W = $clog2(N_CH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  req_i,
  input logic [N_CH-1:0]  en_i,
  input logic [N_CH-1:0]  route_i,
  input logic             fiq_i,
  input logic             irq_i,
  input logic [IDX_W-1:0] fiq_idx_i,
  input logic [IDX_W-1:0] irq_idx_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  logic [N_CH-1:0] want_f, want_i;
  assign want_f = req_i & en_i & route_i;
  assign want_i = req_i & en_i & ~route_i;

  p_fiq_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> fiq_i == (|$past(want_f)));

  p_irq_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> irq_i == (|$past(want_i)));

  p_fiq_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && fiq_i) |-> ($past(want_f) >> fiq_idx_i) == N_CH'(1));

  p_irq_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_i) |-> ($past(want_i) >> irq_idx_i) == N_CH'(1));

  p_fiq_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_i |-> fiq_idx_i == '0);

  p_irq_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |-> irq_idx_i == '0);
endmodule

bind irq_vec_ctrl ivc_checker #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .en_i      (en_q),
  .route_i   (route_q),
  .fiq_i     (fiq_o),
  .irq_i     (irq_o),
  .fiq_idx_i (fiq_idx_q),
  .irq_idx_i (irq_idx_q)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  localparam int N = 32;
  localparam int LIMIT = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          fiq, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl #(.N_CH(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fiq_o(fiq), .irq_o(irq)
  );

  // reference model state
  logic [N-1:0] m_en, m_route;
  bit m_fiq, m_irq;
  int m_fidx, m_iidx;

  function automatic int top_of(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [N-1:0] vec_of(input bit v, input int idx);
    logic [N-1:0] w = '0;
    if (v) begin
      w[N-1] = 1'b1;
      w[4:0] = idx[4:0];
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0; m_route <= '0; m_fiq <= 0; m_irq <= 0; m_fidx <= 0; m_iidx <= 0;
    end else begin
      m_fiq  <= |(req & m_en & m_route);
      m_irq  <= |(req & m_en & ~m_route);
      m_fidx <= top_of(req & m_en & m_route);
      m_iidx <= top_of(req & m_en & ~m_route);
      if (we && addr == 3'd1) m_en    <= wdata;
      if (we && addr == 3'd0) m_route <= wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_route;
      3'd1: return m_en;
      3'd2: return vec_of(m_fiq, m_fidx);
      3'd3: return vec_of(m_irq, m_iidx);
      default: return '0;
    endcase
  endfunction

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] e;
      string t;
      e = m_rd(addr);
      t = (addr < 3'd2) ? "R10" : (addr == 3'd2) ? "R4" : (addr == 3'd3) ? "R5" : "R9";
      chk(fiq == m_fiq, "R2 fiq_o", N'(fiq), N'(m_fiq));
      chk(irq == m_irq, "R3 irq_o", N'(irq), N'(m_irq));
      chk(rdata === e, t, rdata, e);
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, LIMIT);
      summary();
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    we = 1; addr = a; wdata = d; step(); we = 0;
  endtask

  task automatic look(input logic [2:0] a);
    addr = a; @(negedge clk); #0.5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    look(3'd1); chk(rdata == '0, "R1 enable", rdata, '0);
    look(3'd0); chk(rdata == '0, "R1 route", rdata, '0);

    // R8 all requests while disabled; R6 idle vectors
    req = '1; step(); step();
    look(3'd2); chk(rdata == '0, "R6 fiq vec", rdata, '0);
    look(3'd3); chk(rdata == '0, "R8 irq vec", rdata, '0);
    chk(!fiq && !irq, "R8 outputs", N'({fiq, irq}), '0);

    // enable all, route normal: top channel wins
    wr(3'd1, '1); step();
    look(3'd3); chk(rdata == {1'b1, 26'd0, 5'd31}, "R5 top ch", rdata, {1'b1, 26'd0, 5'd31});

    // channel 31 to fast, rest normal
    wr(3'd0, 32'h8000_0000); step();
    look(3'd2); chk(rdata == {1'b1, 26'd0, 5'd31}, "R4 fiq 31", rdata, {1'b1, 26'd0, 5'd31});
    look(3'd3); chk(rdata == {1'b1, 26'd0, 5'd30}, "R5 irq 30", rdata, {1'b1, 26'd0, 5'd30});

    // R7 level: single request then drop
    req = 32'h20; step();
    look(3'd3); chk(rdata == {1'b1, 26'd0, 5'd5}, "R7 held", rdata, {1'b1, 26'd0, 5'd5});
    req = '0; step();
    chk(irq == 1'b0, "R7 dropped", N'(irq), '0);
    look(3'd3); chk(rdata == '0, "R7 vec cleared", rdata, '0);

    // R8 disabling the only pending channel
    req = 32'h20; wr(3'd1, ~32'h20); step();
    chk(irq == 1'b0, "R8 masked ch", N'(irq), '0);

    // R9 writes to read-only and unmapped addresses
    wr(3'd2, '1); wr(3'd3, '1); wr(3'd5, '1); wr(3'd7, 32'h1234);
    look(3'd1); chk(rdata == ~32'h20, "R9 enable kept", rdata, ~32'h20);
    look(3'd0); chk(rdata == 32'h8000_0000, "R9 route kept", rdata, 32'h8000_0000);
    look(3'd6); chk(rdata == '0, "R9 unmapped", rdata, '0);

    // randomised traffic compared each cycle
    for (int k = 0; k < 3000; k++) begin
      req  = $urandom;
      if ($urandom_range(0, 3) == 0) req = req & (32'h1 << $urandom_range(0, 31));
      addr = 3'($urandom_range(0, 7));
      we   = ($urandom_range(0, 5) == 0);
      wdata = $urandom;
      step();
    end
    we = 0;
    step(); step();
    summary();
  end
endmodule